// File: doc/BRIEF.md
# Calendar Time-of-Day Counter

This block keeps the date and time as one packed 32-bit word. Each one-cycle strobe on `tick_i` moves the word on by one second. The strobe comes from an external prescaler that pulses once a second. The seconds, minutes and hours follow a 24-hour clock. The day of month, the month and a 6-bit year offset roll over according to month length and leap years. When the calendar control bit is zero, the same register acts as a plain 32-bit binary counter that steps by one on each tick.

Software sets the time, the alarm and the control bits through a single-cycle write port. The current value can be read on `value_o` at all times. When a tick brings the counter to the same value as the alarm register, a one-cycle alarm pulse is raised. An overflow pulse marks the wrap of the counter. It also marks the clear made when the clear-on-alarm bit is set and a tick arrives while the counter equals the alarm value.

Top module: `cal_counter`

## Requirements
- R1: After reset, `value_o` is 0, the alarm register is 0, both control bits are 0 (binary mode), and `alarm_o` and `ovf_o` are low.
- R2: A write with `wr_addr_i`=0 loads the counter, 1 loads the alarm register, and 2 loads the controls: bit 0 selects calendar mode and bit 1 enables clear-on-alarm. The new counter value appears on `value_o` one cycle after the write.
- R3: In a cycle where `wr_en_i` is high, any tick in that cycle is discarded, and `alarm_o` and `ovf_o` are low in the following cycle.
- R4: In binary mode each tick adds 1 to the counter. Going from 0xFFFFFFFF to 0 raises `ovf_o` for one cycle.
- R5: In calendar mode the layout from bit 0 upward is sec[5:0], min[11:6], hour[16:12], day[21:17], month[25:22], year[31:26]. A field at or above its maximum (sec 59, min 59, hour 23) rolls to 0 and carries into the next field.
- R6: The day rolls to 1 and carries into the month when it is at or above the month's length. That length is 30 for months 4, 6, 9 and 11 and 31 for every other month except 2. A month at or above 12 rolls to 1 and carries into the year.
- R7: February has 29 days when the year offset is divisible by 4 and 28 days otherwise.
- R8: A tick at year 63, Dec 31, 23:59:59 gives year 0, Jan 1, 00:00:00 and raises `ovf_o` for one cycle. Other year changes do not raise `ovf_o`.
- R9: `alarm_o` is high for exactly the one cycle after a tick whose result equals the alarm register.
- R10: With clear-on-alarm set, a tick that arrives while the counter equals the alarm register loads the clear value instead of advancing, and raises `ovf_o`. The clear value is 0 in binary mode and year 0, Jan 1, 00:00:00 in calendar mode.
- R11: In a cycle with no tick and no write, the counter holds its value, and `alarm_o` and `ovf_o` are low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-second strobe, one cycle per second |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write target: 0 counter, 1 alarm, 2 control |
| wr_data_i | input | 32 | Write data |
| value_o | output | 32 | Current counter value |
| alarm_o | output | 1 | One-cycle alarm pulse |
| ovf_o | output | 1 | One-cycle overflow / clear pulse |

## Verification
The hardest cases to reach from the ports are the year-63 wrap and the leap-year February boundaries. Reaching them by ticking alone would take tens of years of ticks. The stimulus instead writes packed values that sit one second before each boundary and then ticks once. The alarm and clear-on-alarm cases need the counter to land exactly on the alarm value. The random phase does this by computing, in the bench, the value one to four ticks ahead and writing that value as the alarm. Random writes of any 32-bit pattern also exercise the rule that a field at or above its maximum rolls over.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int SEC_W  = 6;
  localparam int MIN_W  = 6;
  localparam int HOUR_W = 5;
  localparam int DAY_W  = 5;
  localparam int MON_W  = 4;
  localparam int YEAR_W = 6;
  localparam int VAL_W  = SEC_W + MIN_W + HOUR_W + DAY_W + MON_W + YEAR_W;

  typedef struct packed {
    logic [YEAR_W-1:0] year;
    logic [MON_W-1:0]  month;
    logic [DAY_W-1:0]  day;
    logic [HOUR_W-1:0] hour;
    logic [MIN_W-1:0]  min;
    logic [SEC_W-1:0]  sec;
  } cal_t;

  typedef enum logic [1:0] {
    ADDR_VALUE = 2'd0,
    ADDR_ALARM = 2'd1,
    ADDR_CTRL  = 2'd2
  } addr_e;

  localparam cal_t CAL_ZERO = '{year: '0, month: MON_W'(1), day: DAY_W'(1),
                                hour: '0, min: '0, sec: '0};

  function automatic logic [DAY_W-1:0] month_days(input logic [MON_W-1:0] mon,
                                                  input logic [YEAR_W-1:0] yr);
    case (mon)
      MON_W'(2):  month_days = (yr[1:0] == 2'b00) ? DAY_W'(29) : DAY_W'(28);
      MON_W'(4), MON_W'(6), MON_W'(9), MON_W'(11): month_days = DAY_W'(30);
      default:    month_days = DAY_W'(31);
    endcase
  endfunction
endpackage

// File: rtl/cal_step.sv
module cal_step
  import cal_pkg::*;
(
  input  cal_t cur_i,
  output cal_t nxt_o,
  output logic wrap_o
);
  logic [DAY_W-1:0] dim;
  logic s_w, m_w, h_w, d_w, mo_w;

  always_comb begin
    dim  = month_days(cur_i.month, cur_i.year);
    s_w  = cur_i.sec >= SEC_W'(59);
    m_w  = s_w && (cur_i.min >= MIN_W'(59));
    h_w  = m_w && (cur_i.hour >= HOUR_W'(23));
    d_w  = h_w && (cur_i.day >= dim);
    mo_w = d_w && (cur_i.month >= MON_W'(12));

    nxt_o     = cur_i;
    nxt_o.sec = s_w ? '0 : cur_i.sec + SEC_W'(1);
    if (s_w)  nxt_o.min   = m_w  ? '0 : cur_i.min + MIN_W'(1);
    if (m_w)  nxt_o.hour  = h_w  ? '0 : cur_i.hour + HOUR_W'(1);
    if (h_w)  nxt_o.day   = d_w  ? DAY_W'(1) : cur_i.day + DAY_W'(1);
    if (d_w)  nxt_o.month = mo_w ? MON_W'(1) : cur_i.month + MON_W'(1);
    if (mo_w) nxt_o.year  = cur_i.year + YEAR_W'(1);
    wrap_o = mo_w && (cur_i.year == '1);
  end
endmodule

// File: rtl/bin_step.sv
module bin_step #(
  parameter int W = 32
) (
  input  logic [W-1:0] cur_i,
  output logic [W-1:0] nxt_o,
  output logic         wrap_o
);
  assign nxt_o  = cur_i + W'(1);
  assign wrap_o = &cur_i;
endmodule

// File: rtl/val_match.sv
module val_match #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         eq_o
);
  assign eq_o = (a_i == b_i);
endmodule

// File: rtl/cal_counter.sv
module cal_counter
  import cal_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [VAL_W-1:0] wr_data_i,
  output logic [VAL_W-1:0] value_o,
  output logic             alarm_o,
  output logic             ovf_o
);
  logic [VAL_W-1:0] val_q, alm_q;
  logic             cal_q, clr_q, alarm_q, ovf_q;

  cal_t             cal_nxt;
  logic             cal_wrap;
  logic [VAL_W-1:0] bin_nxt;
  logic             bin_wrap;
  logic [VAL_W-1:0] step_v, next_v, clear_v;
  logic             step_wrap, ovf_d, hit_cur, hit_nxt, do_clear;

  cal_step u_cal_step (
    .cur_i  (cal_t'(val_q)),
    .nxt_o  (cal_nxt),
    .wrap_o (cal_wrap)
  );

  bin_step #(.W(VAL_W)) u_bin_step (
    .cur_i  (val_q),
    .nxt_o  (bin_nxt),
    .wrap_o (bin_wrap)
  );

  val_match #(.W(VAL_W)) u_match_cur (.a_i(val_q),  .b_i(alm_q), .eq_o(hit_cur));
  val_match #(.W(VAL_W)) u_match_nxt (.a_i(next_v), .b_i(alm_q), .eq_o(hit_nxt));

  always_comb begin
    step_v    = cal_q ? VAL_W'(cal_nxt) : bin_nxt;
    step_wrap = cal_q ? cal_wrap : bin_wrap;
    clear_v   = cal_q ? VAL_W'(CAL_ZERO) : '0;
    do_clear  = clr_q && hit_cur;
    next_v    = do_clear ? clear_v : step_v;
    ovf_d     = do_clear || step_wrap;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q   <= '0;
      alm_q   <= '0;
      cal_q   <= 1'b0;
      clr_q   <= 1'b0;
      alarm_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else if (wr_en_i) begin
      alarm_q <= 1'b0;
      ovf_q   <= 1'b0;
      case (addr_e'(wr_addr_i))
        ADDR_VALUE: val_q <= wr_data_i;
        ADDR_ALARM: alm_q <= wr_data_i;
        ADDR_CTRL: begin
          cal_q <= wr_data_i[0];
          clr_q <= wr_data_i[1];
        end
        default: ;
      endcase
    end else if (tick_i) begin
      val_q   <= next_v;
      alarm_q <= hit_nxt;
      ovf_q   <= ovf_d;
    end else begin
      alarm_q <= 1'b0;
      ovf_q   <= 1'b0;
    end
  end

  assign value_o = val_q;
  assign alarm_o = alarm_q;
  assign ovf_o   = ovf_q;

  assert_write_wins_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 2'd0) |=> (value_o == $past(wr_data_i) && !ovf_o && !alarm_o));

  assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !tick_i) |=> ($stable(value_o) && !alarm_o && !ovf_o));

  assert_alarm_equal_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_o |-> (value_o == alm_q));

  assert_ovf_clear_value_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> (value_o == (cal_q ? VAL_W'(CAL_ZERO) : '0)));

  assert_sec_advance_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_en_i && cal_q && !(clr_q && hit_cur) && val_q[5:0] < 6'd59)
    |=> (value_o[5:0] == 6'($past(value_o[5:0]) + 6'd1)));
endmodule

// File: tb/cal_counter_tb.sv
`timescale 1ns/1ps
module cal_counter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [31:0] wr_data = 32'd0;
  logic [31:0] value;
  logic        alarm, ovf;

  int n_cmp = 0;
  int n_bad = 0;

  logic [31:0] mv = 0, ma = 0;
  bit          mcal = 0, mclr = 0;

  localparam logic [31:0] CZ = (32'd1 << 22) | (32'd1 << 17);

  always #2 clk = ~clk;

  cal_counter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .value_o(value), .alarm_o(alarm), .ovf_o(ovf)
  );

  function automatic logic [31:0] pk(int y, int mo, int d, int h, int mi, int s);
    return {y[5:0], mo[3:0], d[4:0], h[4:0], mi[5:0], s[5:0]};
  endfunction

  function automatic int mlen(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  // returns {wrap, next}
  function automatic logic [32:0] cal_next(logic [31:0] v);
    int s, mi, h, d, mo, y;
    bit w;
    s = v[5:0]; mi = v[11:6]; h = v[16:12]; d = v[21:17]; mo = v[25:22]; y = v[31:26];
    w = 0;
    s = s + 1;
    if (s > 59) begin
      s = 0; mi = mi + 1;
      if (mi > 59) begin
        mi = 0; h = h + 1;
        if (h > 23) begin
          h = 0;
          if (d >= mlen(mo, y)) begin
            d = 1;
            if (mo >= 12) begin
              mo = 1;
              if (y == 63) begin y = 0; w = 1; end else y = y + 1;
            end else mo = mo + 1;
          end else d = d + 1;
        end
      end
    end
    return {w, pk(y, mo, d, h, mi, s)};
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit w, logic [1:0] a, logic [31:0] d, bit tk, string tag);
    logic [32:0] r;
    logic [31:0] nv;
    bit e_al, e_ov;
    @(negedge clk);
    wr_en = w; wr_addr = a; wr_data = d; tick = tk;
    @(posedge clk);
    #1;
    wr_en = 0; tick = 0;
    e_al = 0; e_ov = 0;
    if (w) begin
      case (a)
        2'd0: mv = d;
        2'd1: ma = d;
        2'd2: begin mcal = d[0]; mclr = d[1]; end
        default: ;
      endcase
    end else if (tk) begin
      if (mclr && mv == ma) begin
        nv = mcal ? CZ : 32'd0;
        e_ov = 1;
      end else if (mcal) begin
        r = cal_next(mv); nv = r[31:0]; e_ov = r[32];
      end else begin
        nv = mv + 32'd1; e_ov = (mv == 32'hFFFF_FFFF);
      end
      e_al = (nv == ma);
      mv = nv;
    end
    check(tag, "value", value, mv);
    check(tag, "alarm", {31'd0, alarm}, {31'd0, e_al});
    check(tag, "ovf", {31'd0, ovf}, {31'd0, e_ov});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [32:0] r;
    void'($urandom(32'd5171));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1", "value", value, 32'd0);
    check("R1", "alarm", {31'd0, alarm}, 32'd0);
    check("R1", "ovf", {31'd0, ovf}, 32'd0);
    rst_n = 1'b1;
    step(0, 0, 0, 1, "R1");                  // binary by default: 0 -> 1
    step(0, 0, 0, 0, "R11");
    step(1, 0, 32'd100, 0, "R2");
    step(0, 0, 0, 1, "R4");
    step(1, 0, 32'hFFFF_FFFF, 0, "R2");
    step(0, 0, 0, 1, "R4");                  // wrap with ovf
    step(0, 0, 0, 1, "R4");
    step(1, 0, 32'd55, 1, "R3");             // tick dropped
    step(1, 1, 32'd99, 1, "R3");
    step(0, 0, 0, 0, "R11");
    // alarm in binary
    step(1, 1, 32'd57, 0, "R2");
    step(0, 0, 0, 1, "R9");
    step(0, 0, 0, 1, "R9");
    step(0, 0, 0, 1, "R9");
    // clear-on-alarm, binary
    step(1, 2, 32'd2, 0, "R2");
    step(1, 1, 32'd58, 0, "R2");
    step(0, 0, 0, 1, "R10");
    step(0, 0, 0, 1, "R10");
    step(0, 0, 0, 0, "R11");
    // calendar mode
    step(1, 2, 32'd1, 0, "R2");
    step(1, 0, pk(2, 3, 5, 23, 59, 59), 0, "R2");
    step(0, 0, 0, 1, "R5");
    step(0, 0, 0, 1, "R5");
    step(1, 0, pk(2, 3, 5, 9, 59, 59), 0, "R5");
    step(0, 0, 0, 1, "R5");
    step(1, 0, pk(2, 4, 30, 23, 59, 59), 0, "R6");
    step(0, 0, 0, 1, "R6");
    step(1, 0, pk(2, 1, 31, 23, 59, 59), 0, "R6");
    step(0, 0, 0, 1, "R6");
    step(1, 0, pk(2, 1, 30, 23, 59, 59), 0, "R6");
    step(0, 0, 0, 1, "R6");
    step(1, 0, pk(2, 11, 30, 23, 59, 59), 0, "R6");
    step(0, 0, 0, 1, "R6");
    step(1, 0, pk(4, 2, 28, 23, 59, 59), 0, "R7");
    step(0, 0, 0, 1, "R7");
    step(1, 0, pk(4, 2, 29, 23, 59, 59), 0, "R7");
    step(0, 0, 0, 1, "R7");
    step(1, 0, pk(5, 2, 28, 23, 59, 59), 0, "R7");
    step(0, 0, 0, 1, "R7");
    step(1, 0, pk(10, 12, 31, 23, 59, 59), 0, "R8");
    step(0, 0, 0, 1, "R8");
    step(1, 0, pk(63, 12, 31, 23, 59, 59), 0, "R8");
    step(0, 0, 0, 1, "R8");
    step(0, 0, 0, 1, "R8");
    // calendar alarm and clear
    step(1, 0, pk(7, 6, 30, 23, 59, 58), 0, "R9");
    step(1, 1, pk(7, 7, 1, 0, 0, 0), 0, "R9");
    step(0, 0, 0, 1, "R9");
    step(0, 0, 0, 1, "R9");
    step(1, 2, 32'd3, 0, "R10");
    step(1, 0, pk(7, 7, 1, 0, 0, 0), 0, "R10");
    step(0, 0, 0, 1, "R10");
    step(0, 0, 0, 1, "R10");
    // random phase
    for (int i = 0; i < 4000; i++) begin
      int sel;
      sel = $urandom_range(0, 99);
      if (sel < 3) begin
        step(1, 2, {30'd0, 1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 4) != 0)}, 1, "R2");
      end else if (sel < 7) begin
        case ($urandom_range(0, 2))
          0: v = $urandom;
          1: v = pk($urandom_range(0, 63), $urandom_range(1, 12), $urandom_range(1, 31),
                    $urandom_range(0, 23), $urandom_range(0, 59), $urandom_range(0, 59));
          default: v = pk($urandom_range(0, 63), $urandom_range(1, 12),
                          $urandom_range(27, 31), 23, 59, $urandom_range(55, 59));
        endcase
        step(1, 0, v, $urandom_range(0, 1), "R5 R6 R7");
      end else if (sel < 10) begin
        v = mv;
        for (int k = 0; k < int'($urandom_range(1, 4)); k++) begin
          if (mcal) begin r = cal_next(v); v = r[31:0]; end else v = v + 32'd1;
        end
        step(1, 1, v, 0, "R9");
      end else begin
        step(0, 0, 0, ($urandom_range(0, 9) < 7), "R4 R5 R6 R8 R9 R10 R11");
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule